// File: doc/BRIEF.md
# IN Endpoint Transmit Controller

This block serves the device-to-host direction of a full-speed USB device. Software gives every endpoint one transmit descriptor: the ID of the packet buffer that holds the data, a byte count from 0 to the maximum packet size, a ready flag and a pending flag. When the protocol engine reports an IN token, the block answers with one of three responses. If the endpoint is stalled it answers STALL. If the endpoint is ready it answers DATA and streams the buffer from packet memory, one byte per cycle. Otherwise it answers NACK. For OUT tokens the block answers only the stall question. All other OUT handling belongs to the receive path.

A packet counts as delivered only when the host acknowledges it. At that point the ready flag drops, a sticky sent bit for the endpoint rises and a one-cycle sent pulse fires. Software clears sent bits by writing ones. If the host does not acknowledge, the descriptor stays armed and the next IN token sends the same bytes again.

A SETUP token to an endpoint clears that endpoint's stall bit. If the endpoint had data queued, the SETUP also withdraws it, marking it pending so software can queue it again later. A link reset withdraws queued data on every endpoint in the same way and aborts any packet that is being streamed.

Top module: `in_ep_tx`

## Requirements
- R1: After reset the ready, pending, stall and sent vectors are all zero, no response is valid, no memory read is issued and the interrupt output is low.
- R2: A descriptor write stores the buffer ID, the length and the ready flag for the addressed endpoint and clears its pending flag. The new state is visible on the first cycle after the write.
- R3: An IN token to an endpoint that is ready and not stalled gives response code 3 (DATA) one cycle later, with reads issued in that same cycle. The reads go to byte address {buffer ID, offset} for offsets 0 to length-1. Byte i appears on the transmit data output i+2 cycles after the token, flagged valid. The done strobe comes with the last byte, or together with the response when the length is zero, in which case no read is made.
- R4: An IN token to an endpoint that is neither ready nor stalled gives response code 1 (NACK).
- R5: Software can set a stall bit for each endpoint. An IN or OUT token to a stalled endpoint gives code 2 (STALL), and this wins even when the endpoint is ready. An OUT token to an endpoint that is not stalled gives code 0 (pass to the receive path).
- R6: A host ACK after a packet's done strobe clears that endpoint's ready flag, sets its sent bit and pulses the sent output for one cycle, all on the following cycle. The interrupt output stays high while any sent bit is set.
- R7: A host timeout after a packet leaves the ready flag set, and the next IN token streams the same bytes again.
- R8: Writing 1 to a bit of the sent-clear input clears that sent bit. A bit written as 0 leaves its sent bit unchanged.
- R9: A SETUP token to an endpoint clears its stall bit and, if the endpoint was ready, clears ready and sets pending. Other endpoints are not affected. The next IN token to that endpoint gets a NACK.
- R10: A link reset clears ready on every endpoint, sets pending on each endpoint that was ready, and aborts any packet being streamed. A later IN token gets a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| desc_we_i | input | 1 | Descriptor write strobe |
| desc_ep_i | input | EP_W | Endpoint addressed by the write |
| desc_buf_i | input | BUF_ID_W | Buffer ID to store |
| desc_len_i | input | LEN_W | Packet length in bytes |
| desc_rdy_i | input | 1 | Ready flag to store |
| stall_set_i | input | NUM_EP | Per-endpoint stall set bits |
| sent_clr_i | input | NUM_EP | Per-endpoint write-1-to-clear for sent bits |
| tok_in_i | input | 1 | IN token seen |
| tok_out_i | input | 1 | OUT token seen |
| tok_setup_i | input | 1 | SETUP token seen |
| tok_ep_i | input | EP_W | Endpoint of the token |
| host_ack_i | input | 1 | Host acknowledged the last packet |
| host_timeout_i | input | 1 | No handshake arrived from the host |
| link_reset_i | input | 1 | Link reset detected |
| resp_valid_o | output | 1 | Response code is valid |
| resp_o | output | 2 | 0 pass, 1 NACK, 2 STALL, 3 DATA |
| mem_req_o | output | 1 | Packet memory read request |
| mem_addr_o | output | ADDR_W | Byte address of the read |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_data_o | output | 8 | Transmit byte |
| tx_done_o | output | 1 | Last byte of the packet, or end of an empty packet |
| rdy_o | output | NUM_EP | Ready flags |
| pend_o | output | NUM_EP | Pending flags |
| stall_o | output | NUM_EP | Stall bits |
| sent_o | output | NUM_EP | Sticky sent bits |
| pkt_sent_o | output | 1 | One-cycle pulse when a packet is acknowledged |
| irq_sent_o | output | 1 | Level interrupt while any sent bit is set |

## Verification
Results fall into three latency classes, counted from the clock edge that samples the stimulus. Descriptor, flag and response changes appear after that same edge. Streamed byte i appears i+1 edges after the response, because of the one-cycle memory read. The done strobe comes with the last byte, and the ACK effects appear one edge after the ACK. The bench drives inputs just after a falling edge and samples at the next falling edge. Because of that, each check lands on the exact cycle given above instead of waiting for an arbitrary later one. For stream checks, the bench's own memory model returns data one cycle after the address, and the expected bytes come from that model.

// File: rtl/in_ep_tx_pkg.sv
package in_ep_tx_pkg;

    typedef enum logic [1:0] {
        RESP_PASS  = 2'd0,
        RESP_NACK  = 2'd1,
        RESP_STALL = 2'd2,
        RESP_DATA  = 2'd3
    } resp_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_WAIT = 2'd2
    } tx_st_e;

endpackage

// File: rtl/in_ep_desc_bank.sv
module in_ep_desc_bank #(
    parameter int NUM_EP   = 4,
    parameter int EP_W     = 2,
    parameter int BUF_ID_W = 5,
    parameter int LEN_W    = 7
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               desc_we_i,
    input  logic [EP_W-1:0]                    desc_ep_i,
    input  logic [BUF_ID_W-1:0]                desc_buf_i,
    input  logic [LEN_W-1:0]                   desc_len_i,
    input  logic                               desc_rdy_i,
    input  logic [NUM_EP-1:0]                  stall_set_i,
    input  logic [NUM_EP-1:0]                  sent_clr_i,
    input  logic                               setup_i,
    input  logic [EP_W-1:0]                    setup_ep_i,
    input  logic                               link_reset_i,
    input  logic [NUM_EP-1:0]                  ack_ep_i,
    output logic [NUM_EP-1:0]                  rdy_o,
    output logic [NUM_EP-1:0]                  pend_o,
    output logic [NUM_EP-1:0]                  stall_o,
    output logic [NUM_EP-1:0]                  sent_o,
    output logic [NUM_EP-1:0][BUF_ID_W-1:0]    buf_o,
    output logic [NUM_EP-1:0][LEN_W-1:0]       len_o
);

    typedef struct packed {
        logic [BUF_ID_W-1:0] bid;
        logic [LEN_W-1:0]    len;
        logic                rdy;
        logic                pend;
        logic                stall;
        logic                sent;
    } desc_t;

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        desc_t ep_d, ep_q;
        logic  wr_hit, setup_hit;

        assign wr_hit    = desc_we_i && (desc_ep_i == EP_W'(e));
        assign setup_hit = setup_i && (setup_ep_i == EP_W'(e));

        // Precedence, lowest first: clear, ack, stall set, SETUP, link reset, write
        always_comb begin
            ep_d = ep_q;
            if (sent_clr_i[e]) ep_d.sent = 1'b0;
            if (ack_ep_i[e]) begin
                ep_d.rdy  = 1'b0;
                ep_d.sent = 1'b1;
            end
            if (stall_set_i[e]) ep_d.stall = 1'b1;
            if (setup_hit) begin
                ep_d.stall = 1'b0;
                if (ep_q.rdy) begin
                    ep_d.rdy  = 1'b0;
                    ep_d.pend = 1'b1;
                end
            end
            if (link_reset_i) begin
                if (ep_q.rdy) ep_d.pend = 1'b1;
                ep_d.rdy = 1'b0;
            end
            if (wr_hit) begin
                ep_d.bid  = desc_buf_i;
                ep_d.len  = desc_len_i;
                ep_d.rdy  = desc_rdy_i;
                ep_d.pend = 1'b0;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) ep_q <= '0;
            else         ep_q <= ep_d;
        end

        assign rdy_o[e]   = ep_q.rdy;
        assign pend_o[e]  = ep_q.pend;
        assign stall_o[e] = ep_q.stall;
        assign sent_o[e]  = ep_q.sent;
        assign buf_o[e]   = ep_q.bid;
        assign len_o[e]   = ep_q.len;

        assert_ack_retires_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (ack_ep_i[e] && !wr_hit) |=> (!rdy_o[e] && sent_o[e]));

        assert_setup_parks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (setup_hit && rdy_o[e] && !wr_hit) |=> (pend_o[e] && !rdy_o[e] && !stall_o[e]));

        assert_link_reset_drops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (link_reset_i && !wr_hit) |=> !rdy_o[e]);
    end

endmodule

// File: rtl/in_ep_tx_fsm.sv
module in_ep_tx_fsm
    import in_ep_tx_pkg::*;
#(
    parameter int NUM_EP   = 4,
    parameter int EP_W     = 2,
    parameter int BUF_ID_W = 5,
    parameter int LEN_W    = 7,
    parameter int OFS_W    = 6
) (
    input  logic                               clk_i,
    input  logic                               rst_ni,
    input  logic                               tok_in_i,
    input  logic                               tok_out_i,
    input  logic [EP_W-1:0]                    tok_ep_i,
    input  logic                               host_ack_i,
    input  logic                               host_timeout_i,
    input  logic                               link_reset_i,
    input  logic [NUM_EP-1:0]                  rdy_i,
    input  logic [NUM_EP-1:0]                  stall_i,
    input  logic [NUM_EP-1:0][BUF_ID_W-1:0]    buf_i,
    input  logic [NUM_EP-1:0][LEN_W-1:0]       len_i,
    output logic [NUM_EP-1:0]                  ack_ep_o,
    output logic                               pkt_sent_o,
    output logic                               resp_valid_o,
    output resp_e                              resp_o,
    output logic                               mem_req_o,
    output logic [BUF_ID_W+OFS_W-1:0]          mem_addr_o,
    output logic                               tx_valid_o,
    output logic                               tx_done_o
);

    typedef struct packed {
        tx_st_e              st;
        logic [EP_W-1:0]     ep;
        logic [BUF_ID_W-1:0] bid;
        logic [LEN_W-1:0]    len;
        logic [LEN_W-1:0]    cnt;
        logic                rv;
        resp_e               rsp;
        logic                txv;
        logic                sent_p;
    } fsm_t;

    fsm_t s_d, s_q;
    logic ack_fire;

    assign mem_req_o  = (s_q.st == TX_SEND) && (s_q.cnt != s_q.len);
    assign tx_done_o  = (s_q.st == TX_SEND) && (s_q.cnt == s_q.len);
    assign mem_addr_o = {s_q.bid, s_q.cnt[OFS_W-1:0]};
    assign ack_fire   = (s_q.st == TX_WAIT) && host_ack_i && !link_reset_i
                        && rdy_i[s_q.ep];

    always_comb begin
        ack_ep_o = '0;
        if (ack_fire) ack_ep_o[s_q.ep] = 1'b1;
    end

    always_comb begin
        s_d        = s_q;
        s_d.rv     = 1'b0;
        s_d.txv    = mem_req_o;
        s_d.sent_p = ack_fire;
        unique case (s_q.st)
            TX_IDLE: begin
                if (tok_in_i) begin
                    s_d.rv = 1'b1;
                    if (stall_i[tok_ep_i]) begin
                        s_d.rsp = RESP_STALL;
                    end else if (rdy_i[tok_ep_i]) begin
                        s_d.rsp = RESP_DATA;
                        s_d.st  = TX_SEND;
                        s_d.ep  = tok_ep_i;
                        s_d.bid = buf_i[tok_ep_i];
                        s_d.len = len_i[tok_ep_i];
                        s_d.cnt = '0;
                    end else begin
                        s_d.rsp = RESP_NACK;
                    end
                end else if (tok_out_i) begin
                    s_d.rv  = 1'b1;
                    s_d.rsp = stall_i[tok_ep_i] ? RESP_STALL : RESP_PASS;
                end
            end
            TX_SEND: begin
                if (mem_req_o) s_d.cnt = s_q.cnt + 1'b1;
                else           s_d.st  = TX_WAIT;
            end
            TX_WAIT: begin
                if (host_ack_i || host_timeout_i) s_d.st = TX_IDLE;
            end
            default: s_d.st = TX_IDLE;
        endcase
        if (link_reset_i) begin
            s_d.st  = TX_IDLE;
            s_d.txv = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign resp_valid_o = s_q.rv;
    assign resp_o       = s_q.rsp;
    assign tx_valid_o   = s_q.txv;
    assign pkt_sent_o   = s_q.sent_p;

    assert_ready_gets_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == TX_IDLE && tok_in_i && !link_reset_i && rdy_i[tok_ep_i] && !stall_i[tok_ep_i])
        |=> (resp_valid_o && resp_o == RESP_DATA));

    assert_byte_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_valid_o |-> $past(mem_req_o));

    assert_stall_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.st == TX_IDLE && (tok_in_i || tok_out_i) && stall_i[tok_ep_i])
        |=> (resp_valid_o && resp_o == RESP_STALL));

    assert_abort_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_reset_i |=> (!mem_req_o && !tx_valid_o && !tx_done_o));

endmodule

// File: rtl/in_ep_tx.sv
module in_ep_tx
    import in_ep_tx_pkg::*;
#(
    parameter int NUM_EP   = 4,
    parameter int BUF_ID_W = 5,
    parameter int MAX_PKT  = 64,
    localparam int EP_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int LEN_W   = $clog2(MAX_PKT + 1),
    localparam int OFS_W   = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1,
    localparam int ADDR_W  = BUF_ID_W + OFS_W
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  desc_we_i,
    input  logic [EP_W-1:0]       desc_ep_i,
    input  logic [BUF_ID_W-1:0]   desc_buf_i,
    input  logic [LEN_W-1:0]      desc_len_i,
    input  logic                  desc_rdy_i,
    input  logic [NUM_EP-1:0]     stall_set_i,
    input  logic [NUM_EP-1:0]     sent_clr_i,
    input  logic                  tok_in_i,
    input  logic                  tok_out_i,
    input  logic                  tok_setup_i,
    input  logic [EP_W-1:0]       tok_ep_i,
    input  logic                  host_ack_i,
    input  logic                  host_timeout_i,
    input  logic                  link_reset_i,
    output logic                  resp_valid_o,
    output logic [1:0]            resp_o,
    output logic                  mem_req_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    input  logic [7:0]            mem_rdata_i,
    output logic                  tx_valid_o,
    output logic [7:0]            tx_data_o,
    output logic                  tx_done_o,
    output logic [NUM_EP-1:0]     rdy_o,
    output logic [NUM_EP-1:0]     pend_o,
    output logic [NUM_EP-1:0]     stall_o,
    output logic [NUM_EP-1:0]     sent_o,
    output logic                  pkt_sent_o,
    output logic                  irq_sent_o
);

    logic [NUM_EP-1:0]                 ack_ep;
    logic [NUM_EP-1:0][BUF_ID_W-1:0]   ep_buf;
    logic [NUM_EP-1:0][LEN_W-1:0]      ep_len;
    resp_e                             resp;

    in_ep_desc_bank #(
        .NUM_EP   (NUM_EP),
        .EP_W     (EP_W),
        .BUF_ID_W (BUF_ID_W),
        .LEN_W    (LEN_W)
    ) i_bank (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .desc_we_i    (desc_we_i),
        .desc_ep_i    (desc_ep_i),
        .desc_buf_i   (desc_buf_i),
        .desc_len_i   (desc_len_i),
        .desc_rdy_i   (desc_rdy_i),
        .stall_set_i  (stall_set_i),
        .sent_clr_i   (sent_clr_i),
        .setup_i      (tok_setup_i),
        .setup_ep_i   (tok_ep_i),
        .link_reset_i (link_reset_i),
        .ack_ep_i     (ack_ep),
        .rdy_o        (rdy_o),
        .pend_o       (pend_o),
        .stall_o      (stall_o),
        .sent_o       (sent_o),
        .buf_o        (ep_buf),
        .len_o        (ep_len)
    );

    in_ep_tx_fsm #(
        .NUM_EP   (NUM_EP),
        .EP_W     (EP_W),
        .BUF_ID_W (BUF_ID_W),
        .LEN_W    (LEN_W),
        .OFS_W    (OFS_W)
    ) i_fsm (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .tok_in_i       (tok_in_i),
        .tok_out_i      (tok_out_i),
        .tok_ep_i       (tok_ep_i),
        .host_ack_i     (host_ack_i),
        .host_timeout_i (host_timeout_i),
        .link_reset_i   (link_reset_i),
        .rdy_i          (rdy_o),
        .stall_i        (stall_o),
        .buf_i          (ep_buf),
        .len_i          (ep_len),
        .ack_ep_o       (ack_ep),
        .pkt_sent_o     (pkt_sent_o),
        .resp_valid_o   (resp_valid_o),
        .resp_o         (resp),
        .mem_req_o      (mem_req_o),
        .mem_addr_o     (mem_addr_o),
        .tx_valid_o     (tx_valid_o),
        .tx_done_o      (tx_done_o)
    );

    assign resp_o     = resp;
    assign tx_data_o  = mem_rdata_i;
    assign irq_sent_o = |sent_o;

    assert_irq_tracks_sent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_sent_o |-> irq_sent_o);

endmodule

// File: tb/test_in_ep_tx.sv
`timescale 1ns/1ps
module test_in_ep_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_we = 1'b0;
    logic [1:0]  desc_ep = '0;
    logic [4:0]  desc_buf = '0;
    logic [6:0]  desc_len = '0;
    logic        desc_rdy = 1'b0;
    logic [3:0]  stall_set = '0;
    logic [3:0]  sent_clr = '0;
    logic        tok_in = 1'b0, tok_out = 1'b0, tok_setup = 1'b0;
    logic [1:0]  tok_ep = '0;
    logic        host_ack = 1'b0, host_timeout = 1'b0, link_reset = 1'b0;
    logic        resp_valid;
    logic [1:0]  resp;
    logic        mem_req;
    logic [10:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        tx_valid, tx_done;
    logic [7:0]  tx_data;
    logic [3:0]  rdy, pend, stall, sent;
    logic        pkt_sent, irq_sent;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [4:0] mdl_buf [4];
    logic [6:0] mdl_len [4];

    always #4 clk = ~clk;

    in_ep_tx i_in_ep_tx (
        .clk_i(clk), .rst_ni(rst_n),
        .desc_we_i(desc_we), .desc_ep_i(desc_ep), .desc_buf_i(desc_buf),
        .desc_len_i(desc_len), .desc_rdy_i(desc_rdy),
        .stall_set_i(stall_set), .sent_clr_i(sent_clr),
        .tok_in_i(tok_in), .tok_out_i(tok_out), .tok_setup_i(tok_setup), .tok_ep_i(tok_ep),
        .host_ack_i(host_ack), .host_timeout_i(host_timeout), .link_reset_i(link_reset),
        .resp_valid_o(resp_valid), .resp_o(resp),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_done_o(tx_done),
        .rdy_o(rdy), .pend_o(pend), .stall_o(stall), .sent_o(sent),
        .pkt_sent_o(pkt_sent), .irq_sent_o(irq_sent)
    );

    function automatic logic [7:0] pat(input logic [10:0] a);
        return a[7:0] ^ {a[10:8], 5'b10110};
    endfunction

    // packet memory model: one cycle read latency
    always @(posedge clk) if (mem_req) mem_rdata <= pat(mem_addr);

    localparam logic [1:0] C_PASS = 2'd0, C_NACK = 2'd1, C_STALL = 2'd2, C_DATA = 2'd3;

    typedef struct packed {
        logic       is_in;
        logic [1:0] ep;
        logic [1:0] exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b1, 2'd1, C_NACK},
        '{1'b1, 2'd2, C_STALL},
        '{1'b1, 2'd3, C_STALL},
        '{1'b0, 2'd2, C_STALL},
        '{1'b0, 2'd1, C_PASS},
        '{1'b1, 2'd0, C_DATA},
        '{1'b1, 2'd0, C_DATA}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic write_desc(input logic [1:0] ep, input logic [4:0] b,
                              input logic [6:0] l, input logic r);
        desc_we = 1'b1; desc_ep = ep; desc_buf = b; desc_len = l; desc_rdy = r;
        step();
        desc_we = 1'b0;
        mdl_buf[ep] = b; mdl_len[ep] = l;
    endtask

    task automatic token(input int kind, input logic [1:0] ep);
        tok_ep = ep;
        tok_in = (kind == 0); tok_out = (kind == 1); tok_setup = (kind == 2);
        step();
        tok_in = 1'b0; tok_out = 1'b0; tok_setup = 1'b0;
    endtask

    // called at the negedge right after the IN token edge
    task automatic stream(input logic [1:0] ep);
        check("R3 data response", {resp_valid, resp}, {1'b1, C_DATA});
        if (mdl_len[ep] == 0) begin
            check("R3 empty packet done", {tx_done, mem_req, tx_valid}, 3'b100);
        end else begin
            check("R3 first read", {mem_req, mem_addr}, {1'b1, mdl_buf[ep], 6'd0});
            for (int i = 0; i < int'(mdl_len[ep]); i++) begin
                step();
                check("R3 byte", {tx_valid, tx_data}, {1'b1, pat({mdl_buf[ep], 6'(i)})});
                check("R3 done strobe", tx_done, (i == int'(mdl_len[ep]) - 1));
            end
        end
        step();
    endtask

    task automatic handshake(input bit ack);
        host_ack = ack; host_timeout = !ack;
        step();
        host_ack = 1'b0; host_timeout = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < 4; e++) begin mdl_buf[e] = '0; mdl_len[e] = '0; end
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 flags", {rdy, pend, stall, sent}, 16'h0);
        check("R1 outputs", {resp_valid, mem_req, tx_valid, pkt_sent, irq_sent}, 5'b0);

        // R2 descriptor writes, R5 stall set
        write_desc(2'd0, 5'd5, 7'd3, 1'b1);
        write_desc(2'd3, 5'd9, 7'd2, 1'b1);
        stall_set = 4'b1100; step(); stall_set = '0;
        check("R2 ready after write", rdy, 4'b1001);
        check("R5 stall bits", stall, 4'b1100);

        // table walk: R4, R5, R3, R7
        foreach (VECS[v]) begin
            token(VECS[v].is_in ? 0 : 1, VECS[v].ep);
            if (VECS[v].exp == C_DATA) begin
                stream(VECS[v].ep);
                handshake(1'b0);
                check("R7 ready kept after timeout", rdy[VECS[v].ep], 1'b1);
            end else begin
                check("R4/R5 token response", {resp_valid, resp}, {1'b1, VECS[v].exp});
            end
        end

        // R6 ack retires the packet
        token(0, 2'd0);
        stream(2'd0);
        handshake(1'b1);
        check("R6 ack effects", {pkt_sent, rdy[0], sent, irq_sent}, {1'b1, 1'b0, 4'b0001, 1'b1});
        step();
        check("R6 pulse one cycle", pkt_sent, 1'b0);

        // R8 write-1-to-clear
        sent_clr = 4'b0010; step(); sent_clr = '0;
        check("R8 zero bit ignored", sent, 4'b0001);
        sent_clr = 4'b0001; step(); sent_clr = '0;
        check("R8 clear", {sent, irq_sent}, {4'b0000, 1'b0});

        // R3 zero-length packet
        write_desc(2'd1, 5'd7, 7'd0, 1'b1);
        token(0, 2'd1);
        stream(2'd1);
        handshake(1'b1);
        check("R3 empty packet acked", {rdy[1], sent[1]}, 2'b01);

        // R9 SETUP cancels and unstalls
        write_desc(2'd0, 5'd12, 7'd2, 1'b1);
        token(2, 2'd3);
        check("R9 setup ready", rdy, 4'b0001);
        check("R9 setup pending", pend, 4'b1000);
        check("R9 setup stall", stall, 4'b0100);
        token(0, 2'd3);
        check("R9 nack after setup", {resp_valid, resp}, {1'b1, C_NACK});
        write_desc(2'd3, 5'd9, 7'd2, 1'b1);
        check("R2 write clears pending", {rdy, pend}, {4'b1001, 4'b0000});

        // R10 link reset mid-stream
        token(0, 2'd0);
        check("R10 stream started", {resp_valid, resp, mem_req}, {1'b1, C_DATA, 1'b1});
        link_reset = 1'b1; step(); link_reset = 1'b0;
        check("R10 flags", {rdy, pend}, {4'b0000, 4'b1001});
        check("R10 aborted", {mem_req, tx_valid, tx_done}, 3'b000);
        token(0, 2'd0);
        check("R10 nack after reset", {resp_valid, resp}, {1'b1, C_NACK});

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule